// File: doc/BRIEF.md
# Segment Register Address Translator

This block turns a short virtual address into a physical address by way of a table of eight segment registers that sits inside the processor. The top bits of each incoming address choose a register set. Each set holds a base, a limit and a valid flag. If the selected set is enabled and the offset lies below its limit, the block adds the base to the offset. Otherwise it reports an access error.

Requests arrive with a valid/ready handshake. Each accepted request yields a registered result one cycle later, marked by a response strobe. The table can be changed only through a configuration port, and that port obeys a privilege input. A write presented without privilege leaves the table untouched and raises a one-cycle denial flag. Software can therefore never reprogram its own translation without privilege.

Top module: `seg_translator`

## Requirements
- R1: The virtual address `reqAddr` is 8 bits wide. Bits [7:5] select the segment (0 to 7) and bits [4:0] form the offset.
- R2: Reset clears the valid flag of every segment, so any request accepted after reset and before a privileged write returns an error. During reset, `rspValid` and `cfgDenied` are low.
- R3: A request that hits a segment with its valid flag clear returns `rspErr`=1 and `rspAddr`=0.
- R4: The offset must be strictly less than the segment limit, which is 6 bits wide (0 to 32). An offset equal to or above the limit gives `rspErr`=1 and `rspAddr`=0, so a limit of 0 rejects every offset.
- R5: When a request passes the checks, `rspAddr` equals base plus offset and `rspErr` is 0.
- R6: The base is 8 bits wide. If base plus offset exceeds 255, the request gives `rspErr`=1 and `rspAddr`=0.
- R7: A request is accepted in a cycle where both `reqValid` and `reqReady` are high. `rspValid` is high in exactly the cycle after each accepted request and low otherwise.
- R8: A write presented with `cfgWrite`=1 and `cfgPriv`=0 leaves the table unchanged, and `cfgDenied` is high for the single following cycle.
- R9: A write presented with `cfgWrite`=1 and `cfgPriv`=1 loads base, limit and valid flag into the entry named by `cfgIndex`, and requests accepted in later cycles see the new entry. `reqReady` is low in any cycle that carries such a write.
- R10: `rspAddr` and `rspErr` keep their values through cycles in which no request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Block can accept a request this cycle |
| reqAddr | input | 8 | Virtual address: segment in the top 3 bits, offset in the low 5 bits |
| rspValid | output | 1 | Result strobe, one cycle after acceptance |
| rspAddr | output | 8 | Physical address (0 on error) |
| rspErr | output | 1 | Access error for the presented result |
| cfgWrite | input | 1 | Table write request |
| cfgPriv | input | 1 | Privilege qualifier for table writes |
| cfgIndex | input | 3 | Segment entry to write |
| cfgBase | input | 8 | New base value |
| cfgLimit | input | 6 | New limit value (0 to 32) |
| cfgValid | input | 1 | New valid flag |
| cfgDenied | output | 1 | Pulse: an unprivileged write was dropped |

## Verification
A corrupted table entry shows up on the first translation that uses the entry. A wrong base changes `rspAddr`, while a wrong limit or valid flag moves the error boundary. Any of these appears one cycle after the request. An unprivileged write that leaked into the table is exposed by the next request to that segment, which still expects the old result. A stuck result register shows as `rspValid` out of step with acceptance, or as `rspAddr` drifting in idle cycles.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadResult;
    logic writeEntry;
    logic flagDenied;
  } seg_ctl_t;

endpackage

// File: rtl/seg_ctrl.sv
module seg_ctrl
  import seg_xlat_pkg::*;
(
  input  logic     reqValid,
  input  logic     cfgWrite,
  input  logic     cfgPriv,
  output logic     reqReady,
  output seg_ctl_t ctl
);

  logic privWrite;

  // A privileged table update owns the cycle; requests wait behind it.
  assign privWrite      = cfgWrite & cfgPriv;
  assign reqReady       = ~privWrite;

  assign ctl.loadResult = reqValid & ~privWrite;
  assign ctl.writeEntry = privWrite;
  assign ctl.flagDenied = cfgWrite & ~cfgPriv;

endmodule

// File: rtl/seg_datapath.sv
module seg_datapath
  import seg_xlat_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 5,
  parameter int PA_W  = 8,
  localparam int VA_W    = SEG_W + OFF_W,
  localparam int LIM_W   = OFF_W + 1,
  localparam int NUM_SEG = 1 << SEG_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  seg_ctl_t         ctl,
  input  logic [VA_W-1:0]  reqAddr,
  input  logic [SEG_W-1:0] cfgIndex,
  input  logic [PA_W-1:0]  cfgBase,
  input  logic [LIM_W-1:0] cfgLimit,
  input  logic             cfgValid,
  output logic             rspValid,
  output logic [PA_W-1:0]  rspAddr,
  output logic             rspErr,
  output logic             cfgDenied
);

  logic [PA_W-1:0]  baseQ  [NUM_SEG];
  logic [LIM_W-1:0] limitQ [NUM_SEG];
  logic [NUM_SEG-1:0] enQ;

  // One register set per segment
  for (genvar i = 0; i < NUM_SEG; i++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ[i]  <= '0;
        limitQ[i] <= '0;
        enQ[i]    <= 1'b0;
      end else if (ctl.writeEntry && cfgIndex == SEG_W'(i)) begin
        baseQ[i]  <= cfgBase;
        limitQ[i] <= cfgLimit;
        enQ[i]    <= cfgValid;
      end
    end
  end

  logic [SEG_W-1:0] segSel;
  logic [OFF_W-1:0] offset;
  logic [PA_W:0]    sum;
  logic             fault;

  assign segSel = reqAddr[VA_W-1:OFF_W];
  assign offset = reqAddr[OFF_W-1:0];

  always_comb begin
    sum   = {1'b0, baseQ[segSel]} + (PA_W+1)'(offset);
    fault = ~enQ[segSel]
          | ({1'b0, offset} >= limitQ[segSel])
          | sum[PA_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspAddr   <= '0;
      rspErr    <= 1'b0;
      cfgDenied <= 1'b0;
    end else begin
      rspValid  <= ctl.loadResult;
      cfgDenied <= ctl.flagDenied;
      if (ctl.loadResult) begin
        rspErr  <= fault;
        rspAddr <= fault ? '0 : sum[PA_W-1:0];
      end
    end
  end

endmodule

// File: rtl/seg_translator.sv
module seg_translator
  import seg_xlat_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 5,
  parameter int PA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [SEG_W+OFF_W-1:0] reqAddr,
  output logic               rspValid,
  output logic [PA_W-1:0]    rspAddr,
  output logic               rspErr,
  input  logic               cfgWrite,
  input  logic               cfgPriv,
  input  logic [SEG_W-1:0]   cfgIndex,
  input  logic [PA_W-1:0]    cfgBase,
  input  logic [OFF_W:0]     cfgLimit,
  input  logic               cfgValid,
  output logic               cfgDenied
);

  seg_ctl_t ctl;

  seg_ctrl u_ctrl (
    .reqValid (reqValid),
    .cfgWrite (cfgWrite),
    .cfgPriv  (cfgPriv),
    .reqReady (reqReady),
    .ctl      (ctl)
  );

  seg_datapath #(
    .SEG_W (SEG_W),
    .OFF_W (OFF_W),
    .PA_W  (PA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqAddr   (reqAddr),
    .cfgIndex  (cfgIndex),
    .cfgBase   (cfgBase),
    .cfgLimit  (cfgLimit),
    .cfgValid  (cfgValid),
    .rspValid  (rspValid),
    .rspAddr   (rspAddr),
    .rspErr    (rspErr),
    .cfgDenied (cfgDenied)
  );

endmodule

// File: rtl/seg_translator_chk.sv
module seg_translator_chk #(
  parameter int PA_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic            rspValid,
  input logic [PA_W-1:0] rspAddr,
  input logic            rspErr,
  input logic            cfgWrite,
  input logic            cfgPriv,
  input logic            cfgDenied
);

  // R7: a response follows each accepted request
  a_r7_rsp_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);

  // R7: no response without an accepted request
  a_r7_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> !rspValid);

  // R3: an error carries a zero address
  a_r3_err_zero_addr: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr) |-> (rspAddr == '0));

  // R8: a dropped write is flagged
  a_r8_denied_flag: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && !cfgPriv) |=> cfgDenied);

  // R8: the flag is a single-cycle pulse tied to a dropped write
  a_r8_denied_only: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWrite && !cfgPriv) |=> !cfgDenied);

  // R9: a privileged write stalls requests
  a_r9_stall_on_write: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && cfgPriv) |-> !reqReady);

  // R10: the result holds when nothing is accepted
  a_r10_hold_result: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> ($stable(rspAddr) && $stable(rspErr)));

endmodule

bind seg_translator seg_translator_chk #(.PA_W(PA_W)) u_chk (.*);

// File: tb/sim_seg_translator.sv
`timescale 1ns/1ps
module sim_seg_translator;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic [7:0] reqAddr = '0;
  logic       rspValid;
  logic [7:0] rspAddr;
  logic       rspErr;
  logic       cfgWrite = 1'b0;
  logic       cfgPriv = 1'b0;
  logic [2:0] cfgIndex = '0;
  logic [7:0] cfgBase = '0;
  logic [5:0] cfgLimit = '0;
  logic       cfgValid = 1'b0;
  logic       cfgDenied;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  int cycles = 0;

  // Reference table built from the writes the bench issues
  logic [7:0] mBase  [8];
  logic [5:0] mLimit [8];
  logic       mEn    [8];

  always #4 clk = ~clk;

  seg_translator u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] model(input logic [7:0] a);
    logic [2:0] s;
    logic [4:0] o;
    logic [8:0] sum;
    s = a[7:5];
    o = a[4:0];
    sum = {1'b0, mBase[s]} + {4'b0, o};
    if (!mEn[s] || {1'b0, o} >= mLimit[s] || sum[8]) return {1'b1, 8'h00};
    return {1'b0, sum[7:0]};
  endfunction

  task automatic doWrite(input logic priv, input logic [2:0] idx, input logic [7:0] b,
                         input logic [5:0] lim, input logic en);
    @(negedge clk);
    cfgWrite = 1'b1; cfgPriv = priv; cfgIndex = idx;
    cfgBase = b; cfgLimit = lim; cfgValid = en;
    if (priv) begin
      mBase[idx] = b; mLimit[idx] = lim; mEn[idx] = en;
    end
    @(negedge clk);
    cfgWrite = 1'b0; cfgPriv = 1'b0;
    check(priv ? "R9 no denial on privileged write" : "R8 denial pulse",
          32'(cfgDenied), 32'(!priv));
  endtask

  task automatic doReq(input string req, input logic [7:0] a);
    logic [8:0] e;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    e = model(a);
    @(negedge clk);
    reqValid = 1'b0;
    check({req, " rspValid"}, 32'(rspValid), 32'd1);
    check({req, " rspErr"},   32'(rspErr),   32'(e[8]));
    check({req, " rspAddr"},  32'(rspAddr),  32'(e[7:0]));
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !finished) begin
      nFails++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      mBase[i] = '0; mLimit[i] = '0; mEn[i] = 1'b0;
    end
    void'($urandom(32'd1729));
    repeat (3) @(negedge clk);
    check("R2 rspValid in reset", 32'(rspValid), 32'd0);
    check("R2 cfgDenied in reset", 32'(cfgDenied), 32'd0);
    rstN = 1'b1;

    // R2: every segment invalid after reset
    doReq("R2 seg3 after reset", 8'h6A);
    doReq("R2 seg0 after reset", 8'h00);

    // R1/R5/R4: segment 2 base 0x40 limit 10
    doWrite(1'b1, 3'd2, 8'h40, 6'd10, 1'b1);
    doReq("R5 seg2 off9", {3'd2, 5'd9});
    doReq("R4 seg2 off10 equals limit", {3'd2, 5'd10});
    doReq("R1 seg3 unaffected", {3'd3, 5'd9});

    // R4: limit 0 rejects offset 0
    doWrite(1'b1, 3'd4, 8'h10, 6'd0, 1'b1);
    doReq("R4 limit zero", {3'd4, 5'd0});

    // R3: entry written with valid clear
    doWrite(1'b1, 3'd5, 8'h20, 6'd32, 1'b0);
    doReq("R3 invalid entry", {3'd5, 5'd1});

    // R6: base near the top
    doWrite(1'b1, 3'd7, 8'hF0, 6'd32, 1'b1);
    doReq("R6 top fits", {3'd7, 5'd15});
    doReq("R6 overflow", {3'd7, 5'd16});
    doReq("R4 full limit off31", {3'd7, 5'd31});

    // R8: unprivileged write must not change segment 2
    doWrite(1'b0, 3'd2, 8'h00, 6'd32, 1'b1);
    doReq("R8 table unchanged", {3'd2, 5'd1});

    // R10: idle cycle keeps result
    @(negedge clk);
    check("R7 no rsp when idle", 32'(rspValid), 32'd0);
    check("R10 addr held", 32'(rspAddr), 32'h41);

    // R9: privileged write with a request in the same cycle stalls it
    @(negedge clk);
    reqValid = 1'b1; reqAddr = {3'd1, 5'd3};
    cfgWrite = 1'b1; cfgPriv = 1'b1; cfgIndex = 3'd1;
    cfgBase = 8'h80; cfgLimit = 6'd4; cfgValid = 1'b1;
    mBase[1] = 8'h80; mLimit[1] = 6'd4; mEn[1] = 1'b1;
    #1 check("R9 reqReady low during write", 32'(reqReady), 32'd0);
    @(negedge clk);
    cfgWrite = 1'b0; cfgPriv = 1'b0;
    check("R9 stalled request gave no rsp", 32'(rspValid), 32'd0);
    check("R10 addr held over stall", 32'(rspAddr), 32'h41);
    #1 check("R9 reqReady back high", 32'(reqReady), 32'd1);
    @(negedge clk);
    reqValid = 1'b0;
    check("R9 new entry used", 32'(rspAddr), 32'h83);
    check("R7 rsp after retry", 32'(rspValid), 32'd1);

    // Random mix of writes and requests
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 3) == 0)
        doWrite($urandom_range(0, 3) != 0, 3'($urandom), 8'($urandom),
                6'($urandom_range(0, 32)), $urandom_range(0, 4) != 0);
      else
        doReq("R5 random", 8'($urandom));
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule